// File: doc/BRIEF.md
# Cascaded Column Data Loader

This block is the column-data front end of one display driver chip that sits in a chain of identical chips. The chip listens to a shared parallel data bus only while its active-low enable input is low. On each shift strobe it takes either a 4-bit or an 8-bit slice of the bus and builds 8-bit words from those slices. It writes the words into a column data latch, walking the columns upward or downward as a static direction input selects. Once the latch has taken exactly one line of columns, the chip stops taking data. It then pulls its enable output low, and that output is wired to the enable input of the next chip in the chain.

A falling edge on the line pulse input copies the whole data latch into a line latch in one step. The same edge raises the enable output again and clears the word count and the nibble phase, so the chip is ready for the next line. Each column then gets a 2-bit drive-level code. That code depends on the line-latch bit, on the frame polarity input, and on an active-low blanking input that forces every column to the bottom level. The analog output stages that turn these codes into voltages sit outside this block. So does the pad logic that swaps which physical pin serves as enable input and which as enable output when the direction changes.

All inputs are sampled on `clk`. The shift strobe is a one-cycle qualifier, and the line pulse is a level input whose high-to-low transition is detected inside the block.

Top module: `colseg_loader`

## Requirements
- R1: After reset, `en_out_n` is 1 and every column's drive code is 2'b11 (bottom level).
- R2: With `nibble_mode`=0 and `dir_fwd`=1, each accepted strobe takes `bus_data` as one word. For word number w (0-based) and bus bit k, the value lands on column 8w+8-k (columns 1..240), so bit 7 of the first word drives column 1.
- R3: With `nibble_mode`=1, two accepted strobes form one word. The first strobe's `bus_data[3:0]` become word bits 7..4 and the second strobe's `bus_data[3:0]` become word bits 3..0. `bus_data[7:4]` is ignored. A line takes 60 strobes, and columns are assigned as in R2 and R4.
- R4: With `dir_fwd`=0, word bit k of word w lands on column 240-8w-7+k, so the first word fills columns 233..240 with bit 7 on column 240.
- R5: `en_out_n` falls in the cycle after the strobe that completes word 30 and stays low until the next line pulse fall. Strobes while it is low change no latch content.
- R6: Strobes while `en_in_n` is 1 change no latch content and do not advance the word count.
- R7: On a high-to-low transition of `line_pulse`, the line latch takes the data latch, `en_out_n` returns to 1 in the next cycle, and the word count restarts from zero. A strobe in that same cycle is ignored.
- R8: A lone nibble pending in 4-bit mode when `line_pulse` falls is discarded. The next strobe starts a new word.
- R9: While `blank_n` is 0 the line latch is cleared and every drive code is 2'b11. After `blank_n` returns to 1 the codes reflect all-zero column bits until the next line pulse fall.
- R10: With `blank_n`=1, the drive code of a column is registered one cycle after its inputs. With `frame_pol`=1 it is 2'b00 for bit 1 and 2'b01 for bit 0. With `frame_pol`=0 it is 2'b11 for bit 1 and 2'b10 for bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_stb | input | 1 | One-cycle data capture strobe |
| bus_data | input | 8 | Parallel column data bus |
| nibble_mode | input | 1 | 1: 4-bit slices, two per word; 0: full bytes |
| dir_fwd | input | 1 | 1: fill columns upward from column 1; 0: downward from the last column |
| en_in_n | input | 1 | Active-low chip enable from the previous chip |
| line_pulse | input | 1 | Line pulse; its falling edge transfers and re-arms |
| blank_n | input | 1 | Active-low blanking, forces bottom level and clears the line latch |
| frame_pol | input | 1 | Frame polarity selecting the drive-level pair |
| en_out_n | output | 1 | Active-low enable to the next chip |
| drive_code | output | 480 | 2-bit level code per column; bits [2c+1:2c] drive column c+1 |

## Verification
The bench sweeps both bus widths against both fill directions and compares every column's code against a column index computed from the word and bit numbers. A swapped nibble order or an off-by-one slot would show up there as a mirrored or shifted image. It hits the count boundary directly: it checks `en_out_n` just before and just after the final word, then sends extra words that a counter without a stop would write over the first columns. A partial line followed by a full one, and a lone nibble followed by a full 4-bit line, catch a count or nibble phase that survives the line pulse; such a design would hand off early or shift the image by four columns. Blanking is checked both while active and after release, which exposes a design that only masks the outputs and never clears the line latch.

// File: rtl/colseg_pkg.sv
package colseg_pkg;

  // Drive levels ordered from highest to lowest voltage
  typedef enum logic [1:0] {
    LVL_TOP    = 2'b00,
    LVL_HI_MID = 2'b01,
    LVL_LO_MID = 2'b10,
    LVL_BOTTOM = 2'b11
  } drv_lvl_e;

  function automatic drv_lvl_e level_for(input logic pol, input logic on);
    if (pol) return on ? LVL_TOP : LVL_HI_MID;
    else     return on ? LVL_BOTTOM : LVL_LO_MID;
  endfunction

endpackage

// File: rtl/colseg_capture.sv
// Word assembly, word counting and cascade enable generation
module colseg_capture #(
  parameter int NWORDS = 30,
  parameter int WORD_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_stb,
  input  logic [WORD_W-1:0] bus_data,
  input  logic              nibble_mode,
  input  logic              en_in_n,
  input  logic              line_fall,
  output logic              wr_en,
  output logic [CNT_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_word,
  output logic              en_out_n
);
  localparam int HALF_W = WORD_W / 2;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NWORDS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NWORDS);

  logic [CNT_W-1:0]  cnt_q;
  logic              phase_q;
  logic [HALF_W-1:0] hold_q;
  logic              en_out_q;
  logic              take;
  logic              word_done;

  assign take      = shift_stb & ~en_in_n & (cnt_q != FULL_CNT) & ~line_fall;
  assign word_done = take & (~nibble_mode | phase_q);

  always_comb begin
    if (nibble_mode) wr_word = {hold_q, bus_data[HALF_W-1:0]};
    else             wr_word = bus_data;
  end

  assign wr_en    = word_done;
  assign wr_idx   = cnt_q;
  assign en_out_n = en_out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      hold_q   <= '0;
      en_out_q <= 1'b1;
    end else if (line_fall) begin
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      en_out_q <= 1'b1;
    end else if (take) begin
      if (nibble_mode) begin
        phase_q <= ~phase_q;
        if (!phase_q) hold_q <= bus_data[HALF_W-1:0];
      end
      if (word_done) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_IDX) en_out_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/colseg_word_store.sv
// Column data latch: one word slot per 8 columns, direction-dependent placement
module colseg_word_store #(
  parameter int NWORDS = 30,
  parameter int WORD_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [CNT_W-1:0]         wr_idx,
  input  logic [WORD_W-1:0]        wr_word,
  input  logic                     dir_fwd,
  output logic [NWORDS*WORD_W-1:0] latch_bits
);
  logic [WORD_W-1:0] mem [NWORDS];
  logic [WORD_W-1:0] rev_word;
  logic [WORD_W-1:0] placed;
  logic [CNT_W-1:0]  slot;

  always_comb begin
    for (int j = 0; j < WORD_W; j++) rev_word[j] = wr_word[WORD_W-1-j];
    placed = dir_fwd ? rev_word : wr_word;
    slot   = dir_fwd ? wr_idx : (CNT_W'(NWORDS - 1) - wr_idx);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[slot] <= placed;
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_flat
    assign latch_bits[g*WORD_W +: WORD_W] = mem[g];
  end

endmodule

// File: rtl/colseg_line_drive.sv
// Line latch and per-column registered drive level code
module colseg_line_drive
  import colseg_pkg::*;
#(
  parameter int NCOLS = 240
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_fall,
  input  logic               blank_n,
  input  logic               frame_pol,
  input  logic [NCOLS-1:0]   latch_bits,
  output logic [2*NCOLS-1:0] drive_code
);
  logic [NCOLS-1:0] line_q;
  drv_lvl_e         lvl_q [NCOLS];

  always_ff @(posedge clk) begin
    if (rst || !blank_n) line_q <= '0;
    else if (line_fall)  line_q <= latch_bits;
  end

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst || !blank_n) lvl_q[c] <= LVL_BOTTOM;
      else                 lvl_q[c] <= level_for(frame_pol, line_q[c]);
    end
    assign drive_code[2*c +: 2] = lvl_q[c];
  end

endmodule

// File: rtl/colseg_loader.sv
module colseg_loader #(
  parameter int NCOLS  = 240,
  parameter int WORD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_stb,
  input  logic [WORD_W-1:0]  bus_data,
  input  logic               nibble_mode,
  input  logic               dir_fwd,
  input  logic               en_in_n,
  input  logic               line_pulse,
  input  logic               blank_n,
  input  logic               frame_pol,
  output logic               en_out_n,
  output logic [2*NCOLS-1:0] drive_code
);
  localparam int NWORDS = NCOLS / WORD_W;
  localparam int CNT_W  = $clog2(NWORDS + 1);

  logic              lp_q;
  logic              line_fall;
  logic              wr_en;
  logic [CNT_W-1:0]  wr_idx;
  logic [WORD_W-1:0] wr_word;
  logic [NCOLS-1:0]  latch_bits;

  always_ff @(posedge clk) lp_q <= line_pulse;
  assign line_fall = lp_q & ~line_pulse;

  colseg_capture #(.NWORDS(NWORDS), .WORD_W(WORD_W), .CNT_W(CNT_W)) cap_i (
    .clk(clk), .rst(rst), .shift_stb(shift_stb), .bus_data(bus_data),
    .nibble_mode(nibble_mode), .en_in_n(en_in_n), .line_fall(line_fall),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .en_out_n(en_out_n)
  );

  colseg_word_store #(.NWORDS(NWORDS), .WORD_W(WORD_W), .CNT_W(CNT_W)) store_i (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .dir_fwd(dir_fwd), .latch_bits(latch_bits)
  );

  colseg_line_drive #(.NCOLS(NCOLS)) drv_i (
    .clk(clk), .rst(rst), .line_fall(line_fall), .blank_n(blank_n),
    .frame_pol(frame_pol), .latch_bits(latch_bits), .drive_code(drive_code)
  );

endmodule

// File: rtl/colseg_loader_chk.sv
module colseg_loader_chk #(
  parameter int NCOLS = 240
) (
  input logic               clk,
  input logic               rst,
  input logic               en_in_n,
  input logic               line_pulse,
  input logic               blank_n,
  input logic               en_out_n,
  input logic               wr_en,
  input logic [2*NCOLS-1:0] drive_code
);

  // R6
  deselect_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    en_in_n |-> !wr_en);

  // R5
  full_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    !en_out_n |-> !wr_en);

  // R5
  handoff_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(en_out_n) |-> $past(wr_en));

  // R7
  rearm_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(line_pulse) |=> en_out_n);

  // R7
  line_edge_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(line_pulse) |-> !wr_en);

  // R9
  blank_force_chk: assert property (@(posedge clk) disable iff (rst)
    !blank_n |=> (&drive_code));

endmodule

bind colseg_loader colseg_loader_chk #(.NCOLS(NCOLS)) chk_i (
  .clk(clk), .rst(rst), .en_in_n(en_in_n), .line_pulse(line_pulse),
  .blank_n(blank_n), .en_out_n(en_out_n), .wr_en(wr_en),
  .drive_code(drive_code)
);

// File: tb/colseg_loader_tb_top.sv
module colseg_loader_tb_top;
  localparam int NCOLS = 240;
  localparam int NW    = NCOLS / 8;

  logic clk = 1'b0;
  logic rst, shift_stb, nibble_mode, dir_fwd, en_in_n, line_pulse, blank_n, frame_pol;
  logic [7:0] bus_data;
  logic en_out_n;
  logic [2*NCOLS-1:0] drive_code;

  int checks = 0;
  int fails  = 0;
  int wcount = 0;
  bit exp_dlat [NCOLS];
  bit exp_llat [NCOLS];

  always #2 clk = ~clk;

  colseg_loader #(.NCOLS(NCOLS), .WORD_W(8)) dut_i (
    .clk(clk), .rst(rst), .shift_stb(shift_stb), .bus_data(bus_data),
    .nibble_mode(nibble_mode), .dir_fwd(dir_fwd), .en_in_n(en_in_n),
    .line_pulse(line_pulse), .blank_n(blank_n), .frame_pol(frame_pol),
    .en_out_n(en_out_n), .drive_code(drive_code)
  );

  function automatic logic [7:0] pat(input int w, input int seed);
    return 8'((w * 29 + seed * 53 + 7) ^ (seed << 2));
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_drive(input string tag);
    int bad = 0;
    int first = -1;
    logic [1:0] fa = 2'b00;
    logic [1:0] fe = 2'b00;
    for (int c = 0; c < NCOLS; c++) begin
      logic [1:0] e;
      if (!blank_n)       e = 2'b11;
      else if (frame_pol) e = exp_llat[c] ? 2'b00 : 2'b01;
      else                e = exp_llat[c] ? 2'b11 : 2'b10;
      if (drive_code[2*c +: 2] !== e) begin
        if (first < 0) begin first = c; fa = drive_code[2*c +: 2]; fe = e; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: %0d columns wrong, column %0d actual %b expected %b",
               tag, bad, first + 1, fa, fe);
    end
  endtask

  task automatic strobe(input logic [7:0] v);
    @(negedge clk);
    shift_stb = 1'b1;
    bus_data  = v;
    @(negedge clk);
    shift_stb = 1'b0;
  endtask

  task automatic send_word(input logic [7:0] b);
    bit accept = (en_in_n == 1'b0) && (wcount < NW);
    if (nibble_mode) begin
      strobe({~b[7:4], b[7:4]});
      strobe({~b[3:0], b[3:0]});
    end else begin
      strobe(b);
    end
    if (accept) begin
      for (int k = 0; k < 8; k++) begin
        int col = dir_fwd ? (8 * wcount + 8 - k) : (NCOLS - 8 * wcount - 7 + k);
        exp_dlat[col - 1] = b[k];
      end
      wcount++;
    end
  endtask

  task automatic line_edge();
    @(negedge clk);
    line_pulse = 1'b1;
    @(negedge clk);
    line_pulse = 1'b0;
    for (int c = 0; c < NCOLS; c++) exp_llat[c] = blank_n ? exp_dlat[c] : 1'b0;
    wcount = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_pol(input logic p);
    @(negedge clk);
    frame_pol = p;
    @(negedge clk);
  endtask

  task automatic full_line(input int seed);
    for (int w = 0; w < NW; w++) send_word(pat(w, seed));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1..R10 run): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; shift_stb = 1'b0; bus_data = 8'h00; nibble_mode = 1'b0;
    dir_fwd = 1'b1; en_in_n = 1'b1; line_pulse = 1'b0; blank_n = 1'b0;
    frame_pol = 1'b1;
    for (int c = 0; c < NCOLS; c++) begin exp_dlat[c] = 1'b0; exp_llat[c] = 1'b0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check_bit("R1 en_out_n after reset", en_out_n, 1'b1);
    check_drive("R1 drive after reset");

    // R10 levels on an empty line latch
    blank_n = 1'b1;
    set_pol(1'b1);
    check_drive("R10 pol=1 zero bits");
    set_pol(1'b0);
    check_drive("R10 pol=0 zero bits");

    // R2 R3 R4 sweep of width and direction
    for (int cfg = 0; cfg < 4; cfg++) begin
      string tag;
      nibble_mode = cfg[0];
      dir_fwd     = cfg[1];
      en_in_n     = 1'b0;
      tag = $sformatf("%s%s", nibble_mode ? "R3 nibble " : "R2 byte ",
                      dir_fwd ? "upward" : "R4 downward");
      for (int w = 0; w < NW; w++) begin
        if (w == NW - 1) check_bit("R5 en_out_n before last word", en_out_n, 1'b1);
        send_word(pat(w, cfg + 1));
      end
      check_bit("R5 en_out_n after last word", en_out_n, 1'b0);
      for (int x = 0; x < 3; x++) send_word(~pat(x, cfg + 5));
      check_bit("R5 en_out_n held while full", en_out_n, 1'b0);
      line_edge();
      check_bit("R7 en_out_n after line edge", en_out_n, 1'b1);
      set_pol(1'b1);
      check_drive({tag, " R5 extras ignored"});
      set_pol(1'b0);
      check_drive({"R10 pol=0 ", tag});
    end

    // R6 deselected chip ignores the bus
    nibble_mode = 1'b0; dir_fwd = 1'b1; en_in_n = 1'b1;
    full_line(9);
    check_bit("R6 en_out_n stays high when deselected", en_out_n, 1'b1);
    line_edge();
    set_pol(1'b1);
    check_drive("R6 latch unchanged while deselected");

    // R7 count restarts after a partial line
    en_in_n = 1'b0;
    for (int w = 0; w < 10; w++) send_word(pat(w, 11));
    line_edge();
    check_drive("R7 partial line transferred");
    for (int w = 0; w < NW - 1; w++) send_word(pat(w, 12));
    check_bit("R7 count restarted, no early handoff", en_out_n, 1'b1);
    send_word(pat(NW - 1, 12));
    check_bit("R7 handoff after full restarted line", en_out_n, 1'b0);
    line_edge();
    check_drive("R7 full line after restart");

    // R8 orphan nibble dropped at the line edge
    nibble_mode = 1'b1; dir_fwd = 1'b1;
    strobe(8'h5A);
    line_edge();
    check_bit("R8 en_out_n after orphan nibble edge", en_out_n, 1'b1);
    full_line(13);
    check_bit("R8 handoff after 60 nibbles", en_out_n, 1'b0);
    line_edge();
    check_drive("R8 nibble phase realigned");

    // R9 blanking forces bottom level and clears the line latch
    @(negedge clk);
    blank_n = 1'b0;
    for (int c = 0; c < NCOLS; c++) exp_llat[c] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_drive("R9 forced bottom while blanked");
    blank_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_drive("R9 line latch cleared after blanking");
    line_edge();
    check_drive("R9 data latch kept through blanking");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule